// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that follows a chain of descriptors held in memory. Each descriptor occupies four consecutive 32-bit words, at offsets 0, 4, 8 and 12 from a 16-byte aligned base: next pointer, source address, target address, command. Software writes the address of the first descriptor, then sets the run bit. The channel reads the four words, moves the programmed number of bytes one beat at a time, and then either stops or fetches the descriptor named by the next pointer. A chain whose last pointer leads back to an earlier descriptor repeats until software clears run.

Memory is reached through a word-addressed port with byte enables. Read data and an error indication return one cycle after a read request. A beat moves 1, 2 or 4 bytes from the source lane to the target lane. Descriptors that use flow control wait for a peripheral ready input before each burst. The current source, target and remaining length stay readable, so software can work out how much is left.

Register offsets on `reg_addr`: 0 control/status, 1 descriptor pointer, 2 current source, 3 current target, 4 current command, whose bits 12:0 hold the remaining byte count.

Top module: `desc_dma_chan`

## Requirements
- R1: After reset, register 0 reads 0x00000008 (only stopped, bit 3), irq is low and no memory request is made while the channel is stopped.
- R2: Setting run (bit 31 of register 0) while stopped fetches the descriptor at register 1 and copies bytes from source to target. Command bit 31 makes the source address advance by each beat's size, and bit 30 does the same for the target.
- R3: Command bits 15:14 give the beat width (1 = 1 byte, 2 = 2 bytes, 3 or 0 = 4 bytes). A beat writes only the byte lanes it covers, taking bytes from the source lane given by the source address low bits. A beat is shorter than the width when fewer bytes remain.
- R4: Status bit 2 sets when a descriptor with command bit 21 completes, and bit 1 sets when a descriptor with command bit 22 has been fetched. irq is high while any of status bits 2, 1 or 0 is set.
- R5: Writing 1 to status bits 2, 1 or 0 clears them; writing 0 leaves them unchanged.
- R6: After a descriptor, the channel stops if bit 0 of its next pointer is 1. Otherwise it continues at the next pointer with bits 3:0 treated as zero. After a stop, register 1 holds the last descriptor's address.
- R7: A length of zero (command bits 12:0) completes the descriptor without any memory write, still raising its end flag.
- R8: When command bit 29 or 28 is set, the channel waits for periph_rdy before each burst. Bits 17:16 give the burst size: 1 = 8, 2 = 16, 3 = 32 bytes, 0 = one beat. Status bit 8 shows periph_rdy while such a descriptor runs.
- R9: Registers 2, 3 and 4 show the current source address, the current target address and the remaining length while the channel runs.
- R10: Writing register 0 with bit 31 clear while running stops the channel at the next edge; no further memory writes follow.
- R11: A circular chain runs repeatedly, rewriting its targets and raising the end flag on every descriptor that enables it, until run is cleared.
- R12: An error returned with read data sets status bit 0 and stops the channel.
- R13: Status bit 29 is a read/write stop-interrupt enable; while it is set and the channel is stopped, irq is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | MEM_AW | Memory word address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after request |
| mem_err | input | 1 | Error, one cycle after a read request |
| periph_rdy | input | 1 | Peripheral ready for the next burst |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the channel with MEM_AW = 8, a 1 KB memory. That keeps every descriptor, source and target within a few words, and lets the bench preset target words and catch any stray write. Holding periph_rdy low brings the burst wait within reach, so registers 2 to 4 can be read at a known point partway through a transfer. A one-cycle ready pulse shows that exactly one 8-byte burst moves. An error injected on one fetch word reaches the bus-error stop.

// File: rtl/desc_dma_chan.sv
module desc_dma_chan #(
  parameter int MEM_AW = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_err,
  input  logic              periph_rdy,
  output logic              irq
);

  typedef enum logic [2:0] {S_IDLE, S_FREQ, S_FCAP, S_WAIT, S_RD, S_WR, S_DONE} st_t;

  st_t         st;
  logic [31:0] dptr, nxt, src, dst, cmd;
  logic [1:0]  fidx;
  logic [5:0]  bcnt;
  logic        f_end, f_start, f_err, stop_ie;

  wire csr_wr = reg_we && reg_addr == 3'd0;
  wire busy   = st != S_IDLE;
  wire kick   = csr_wr && reg_wdata[31] && !busy;
  wire halt   = csr_wr && !reg_wdata[31] && busy;
  wire flow   = cmd[29] | cmd[28];
  wire [12:0] len = cmd[12:0];

  logic [2:0] wbytes;
  logic [5:0] bbytes;
  always_comb begin
    case (cmd[15:14])
      2'd1:    wbytes = 3'd1;
      2'd2:    wbytes = 3'd2;
      default: wbytes = 3'd4;
    endcase
    case (cmd[17:16])
      2'd1:    bbytes = 6'd8;
      2'd2:    bbytes = 6'd16;
      2'd3:    bbytes = 6'd32;
      default: bbytes = 6'd0;
    endcase
  end

  wire [2:0] nb       = (len < {10'd0, wbytes}) ? len[2:0] : wbytes;
  wire [6:0] bnext    = {1'b0, bcnt} + {4'd0, nb};
  wire       boundary = bnext >= {1'b0, bbytes};

  logic [3:0] lanes;
  always_comb begin
    case (nb)
      3'd1:    lanes = 4'b0001;
      3'd2:    lanes = 4'b0011;
      3'd3:    lanes = 4'b0111;
      default: lanes = 4'b1111;
    endcase
  end

  wire [31:0] shifted = mem_rdata >> {src[1:0], 3'b000};

  assign mem_req   = st == S_FREQ || st == S_RD || (st == S_WR && !mem_err);
  assign mem_we    = st == S_WR && !mem_err;
  assign mem_be    = lanes << dst[1:0];
  assign mem_wdata = shifted << {dst[1:0], 3'b000};
  assign mem_addr  = (st == S_FREQ) ? {dptr[MEM_AW+1:4], fidx} :
                     (st == S_RD)   ? src[MEM_AW+1:2] : dst[MEM_AW+1:2];

  assign irq = f_end | f_start | f_err | (stop_ie & ~busy);

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = {busy, 1'b0, stop_ie, 20'd0, periph_rdy & busy & flow,
                         4'd0, ~busy, f_end, f_start, f_err};
      3'd1: reg_rdata = dptr;
      3'd2: reg_rdata = src;
      3'd3: reg_rdata = dst;
      3'd4: reg_rdata = cmd;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; dptr <= '0; nxt <= '0; src <= '0; dst <= '0; cmd <= '0;
      fidx <= '0; bcnt <= '0;
      f_end <= 1'b0; f_start <= 1'b0; f_err <= 1'b0; stop_ie <= 1'b0;
    end else begin
      if (csr_wr) begin
        stop_ie <= reg_wdata[29];
        if (reg_wdata[2]) f_end   <= 1'b0;
        if (reg_wdata[1]) f_start <= 1'b0;
        if (reg_wdata[0]) f_err   <= 1'b0;
      end
      if (reg_we && reg_addr == 3'd1 && !busy) dptr <= {reg_wdata[31:4], 4'd0};
      case (st)
        S_IDLE: if (kick) begin st <= S_FREQ; fidx <= 2'd0; end
        S_FREQ: st <= S_FCAP;
        S_FCAP: begin
          case (fidx)
            2'd0: nxt <= mem_rdata;
            2'd1: src <= mem_rdata;
            2'd2: dst <= mem_rdata;
            default: cmd <= mem_rdata;
          endcase
          if (mem_err) begin
            f_err <= 1'b1;
            st <= S_IDLE;
          end else if (fidx != 2'd3) begin
            fidx <= fidx + 2'd1;
            st <= S_FREQ;
          end else begin
            bcnt <= '0;
            if (mem_rdata[22]) f_start <= 1'b1;
            if (mem_rdata[12:0] == 13'd0) st <= S_DONE;
            else if (mem_rdata[29] | mem_rdata[28]) st <= S_WAIT;
            else st <= S_RD;
          end
        end
        S_WAIT: if (periph_rdy) st <= S_RD;
        S_RD: st <= S_WR;
        S_WR: begin
          if (mem_err) begin
            f_err <= 1'b1;
            st <= S_IDLE;
          end else begin
            if (cmd[31]) src <= src + {29'd0, nb};
            if (cmd[30]) dst <= dst + {29'd0, nb};
            cmd[12:0] <= len - {10'd0, nb};
            bcnt <= boundary ? 6'd0 : bnext[5:0];
            if (len == {10'd0, nb}) st <= S_DONE;
            else if (flow && boundary) st <= S_WAIT;
            else st <= S_RD;
          end
        end
        S_DONE: begin
          if (cmd[21]) f_end <= 1'b1;
          if (nxt[0]) st <= S_IDLE;
          else begin
            dptr <= {nxt[31:4], 4'd0};
            fidx <= 2'd0;
            st <= S_FREQ;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (halt) st <= S_IDLE;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[3], nxt[3:1], cmd[27:23], cmd[20:18], cmd[13]};

  p_no_req_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !mem_req);
  p_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_be != 4'd0));
  p_wait_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !periph_rdy && !halt) |=> (st == S_WAIT));
  p_len_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && !mem_err) |=> (cmd[12:0] < $past(cmd[12:0])));
  p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (st == S_IDLE));
  p_err_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_err) |-> (st == S_IDLE));

endmodule

// File: tb/sim_desc_dma_chan.sv
module sim_desc_dma_chan;
  localparam int AW = 8;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [2:0] reg_addr = 0; logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we; logic [AW-1:0] mem_addr; logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata; logic mem_err;
  logic periph_rdy = 0, irq;
  logic [31:0] mem [0:255];
  logic pk_en = 0; logic [7:0] pk_addr = 0; logic [31:0] pk_data = 0;
  logic err_en = 0; logic [7:0] err_word = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  desc_dma_chan #(.MEM_AW(AW)) u0 (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_be, .mem_wdata, .mem_rdata, .mem_err, .periph_rdy, .irq);

  always @(posedge clk) begin
    if (pk_en) mem[pk_addr] <= pk_data;
    if (mem_req && mem_we)
      for (int b = 0; b < 4; b++) if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
    mem_err <= err_en && mem_req && !mem_we && mem_addr == err_word;
  end

  localparam logic [31:0] INC_S = 32'h8000_0000, INC_T = 32'h4000_0000, FLOW_S = 32'h2000_0000,
    START_IE = 32'h0040_0000, END_IE = 32'h0020_0000, B8 = 32'h0001_0000,
    W1 = 32'h0000_4000, W4 = 32'h0000_C000;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(logic [31:0] byte_addr, logic [31:0] d);
    @(negedge clk); pk_en = 1; pk_addr = byte_addr[9:2]; pk_data = d;
    @(negedge clk); pk_en = 0;
  endtask

  function automatic logic [31:0] peek(logic [31:0] byte_addr);
    return mem[byte_addr[9:2]];
  endfunction

  task automatic put_desc(logic [31:0] base, logic [31:0] n, logic [31:0] s, logic [31:0] t, logic [31:0] c);
    poke(base, n); poke(base + 4, s); poke(base + 8, t); poke(base + 12, c);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle(string tag);
    logic [31:0] v;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); rd(0, v);
      if (!v[31]) return;
    end
    check({tag, " timeout"}, 32'd1, 32'd0);
  endtask

  task automatic start(logic [31:0] d);
    wr(1, d); wr(0, 32'h8000_0000);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v); check("R1 reset status", v, 32'h8);
    check("R1 reset irq", {31'd0, irq}, 0);
  endtask

  task automatic t_copy;
    logic [31:0] v;
    for (int i = 0; i < 4; i++) poke(32'h100 + 4*i, 32'h1111_0000 + i);
    put_desc(32'h000, 32'h1, 32'h100, 32'h200, INC_S | INC_T | W4 | END_IE | 16);
    start(32'h000); wait_idle("R2");
    for (int i = 0; i < 4; i++) check("R2 copy word", peek(32'h200 + 4*i), 32'h1111_0000 + i);
    rd(0, v); check("R4 end flag", v, 32'hC);
    check("R4 irq", {31'd0, irq}, 1);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    rd(0, v); wr(0, v); rd(0, v);
    check("R5 w1c", v, 32'h8);
    check("R5 irq low", {31'd0, irq}, 0);
  endtask

  task automatic t_bytes;
    logic [31:0] v;
    poke(32'h110, 32'h4433_2211); poke(32'h210, 32'hAABB_CCDD);
    put_desc(32'h010, 32'h1, 32'h110, 32'h210, INC_S | W1 | START_IE | 3);
    start(32'h010); wait_idle("R3");
    check("R3 fixed target byte lane", peek(32'h210), 32'hAABB_CC33);
    rd(3, v); check("R3 target not advanced", v, 32'h210);
    rd(0, v); check("R4 start flag", v, 32'hA);
    wr(0, 32'h2);
  endtask

  task automatic t_chain;
    logic [31:0] v;
    for (int i = 0; i < 3; i++) begin poke(32'h120 + 4*i, 32'hC0DE_0000 + i); poke(32'h220 + 4*i, 0); end
    put_desc(32'h020, 32'h03E, 32'h120, 32'h220, INC_S | INC_T | W4 | 4);
    put_desc(32'h030, 32'h001, 32'h124, 32'h224, INC_S | INC_T | W4 | 8);
    start(32'h020); wait_idle("R6");
    for (int i = 0; i < 3; i++) check("R6 chain word", peek(32'h220 + 4*i), 32'hC0DE_0000 + i);
    rd(1, v); check("R6 last descriptor", v, 32'h030);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    poke(32'h230, 32'h5A5A_5A5A);
    put_desc(32'h040, 32'h1, 32'h130, 32'h230, INC_S | INC_T | W4 | END_IE);
    start(32'h040); wait_idle("R7");
    check("R7 no write", peek(32'h230), 32'h5A5A_5A5A);
    rd(0, v); check("R7 end flag", v, 32'hC);
    wr(0, 32'h4);
  endtask

  task automatic t_flow;
    logic [31:0] v;
    for (int i = 0; i < 6; i++) begin poke(32'h140 + 4*i, 32'hF0F0_0000 + i); poke(32'h240 + 4*i, 0); end
    periph_rdy = 0;
    put_desc(32'h050, 32'h1, 32'h140, 32'h240, INC_S | INC_T | FLOW_S | B8 | W4 | 24);
    start(32'h050);
    repeat (30) @(negedge clk);
    rd(0, v); check("R8 waiting status", v, 32'h8000_0000);
    rd(2, v); check("R9 source before", v, 32'h140);
    rd(4, v); check("R9 length before", {19'd0, v[12:0]}, 24);
    check("R8 no beat without ready", peek(32'h240), 0);
    periph_rdy = 1;
    rd(0, v); check("R8 request pending", v, 32'h8000_0100);
    @(negedge clk); periph_rdy = 0;
    repeat (10) @(negedge clk);
    rd(2, v); check("R9 source after burst", v, 32'h148);
    rd(3, v); check("R9 target after burst", v, 32'h248);
    rd(4, v); check("R9 length after burst", {19'd0, v[12:0]}, 16);
    check("R8 one burst only", peek(32'h248), 0);
    check("R8 burst word", peek(32'h244), 32'hF0F0_0001);
    periph_rdy = 1; wait_idle("R8"); periph_rdy = 0;
    for (int i = 0; i < 6; i++) check("R8 final word", peek(32'h240 + 4*i), 32'hF0F0_0000 + i);
  endtask

  task automatic t_cyclic;
    logic [31:0] v;
    poke(32'h160, 32'h0C0C_0001); poke(32'h164, 32'h0C0C_0002);
    put_desc(32'h060, 32'h070, 32'h160, 32'h260, INC_S | INC_T | W4 | END_IE | 4);
    put_desc(32'h070, 32'h060, 32'h164, 32'h264, INC_S | INC_T | W4 | END_IE | 4);
    start(32'h060);
    repeat (60) @(negedge clk);
    rd(0, v); check("R11 running with end flag", v, 32'h8000_0004);
    check("R11 first target", peek(32'h260), 32'h0C0C_0001);
    poke(32'h260, 0); poke(32'h264, 0);
    repeat (50) @(negedge clk);
    check("R11 rewritten A", peek(32'h260), 32'h0C0C_0001);
    check("R11 rewritten B", peek(32'h264), 32'h0C0C_0002);
    wr(0, 32'h0);
    rd(0, v); check("R10 halted", v & 32'h8000_0008, 32'h8);
    poke(32'h260, 0); poke(32'h264, 0);
    repeat (50) @(negedge clk);
    check("R10 no write after halt", peek(32'h260) | peek(32'h264), 0);
    wr(0, 32'h7);
  endtask

  task automatic t_err;
    logic [31:0] v;
    err_en = 1; err_word = 8'h21;
    put_desc(32'h080, 32'h1, 32'h180, 32'h280, INC_S | INC_T | W4 | 4);
    start(32'h080); wait_idle("R12");
    rd(0, v); check("R12 bus error stop", v, 32'h9);
    check("R12 irq", {31'd0, irq}, 1);
    err_en = 0; wr(0, 32'h1);
  endtask

  task automatic t_stopie;
    logic [31:0] v;
    wr(0, 32'h2000_0000);
    rd(0, v); check("R13 enable readback", v, 32'h2000_0008);
    check("R13 irq when stopped", {31'd0, irq}, 1);
    wr(0, 32'h0);
    check("R13 irq off", {31'd0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_copy; t_w1c; t_bytes; t_chain; t_zero;
    t_flow; t_cyclic; t_err; t_stopie;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule